// File: doc/BRIEF.md
# Sinusoidal PWM Full-Bridge Modulator

This block drives the four gates of an H-bridge so that the bridge output, averaged over each switching period, traces a line-frequency sinusoid. A free-running sawtooth carrier of 2^CARR_W clocks is compared against a duty threshold. That threshold comes from a half-wave reference shape, scaled by a software-free amplitude input and saturated at full duty. The reference is indexed once per carrier period, and 2^IDX_W carrier periods make one line cycle.

A mode input selects between two bridge schemes. In two-level operation both legs switch together with complementary commands, so the averaged output is (2d-1) times the bus. In three-level operation leg A is pulse-width modulated while leg B sits on one rail for a whole half cycle and changes rail only at the reference zero crossings, so the averaged output is plus or minus d times the bus. Each leg passes through its own dead-time unit, which holds both switches of that leg off for a programmable count after every command change. A one-clock sync pulse marks the start of each line cycle.

Top module: `spwm_bridge_mod`

## Requirements
- R1: The carrier counter runs from 0 to 2^CARR_W-1 and wraps. The reference index advances by one at each wrap, and one line cycle is 2^IDX_W carrier periods (2048 clocks with default parameters).
- R2: For carrier period k of a line cycle, with half-cycle position h = k mod H (H = 2^(IDX_W-1)) and C = 2^CARR_W, the shape is s = floor(4·h·(H-h)·C / H²). The magnitude is m = floor(s·amp_scale / 2^AMP_FRAC), so amp_scale = 128 is unity gain with defaults.
- R3: The magnitude m saturates at C, so no amp_scale value drives the duty threshold outside 0..C.
- R4: Magnitude, half-cycle sign and mode are captured only at the carrier wrap. A change of amp_scale or mode_sel in the middle of a carrier period leaves that period's gating unchanged.
- R5: In two-level mode (mode_sel = 0), leg A's high-side command is on while the carrier is below T. T = floor((C+m)/2) in the first half cycle (k < H) and floor((C-m)/2) in the second half cycle. Leg B's command is the complement of leg A's.
- R6: In three-level mode (mode_sel = 1), leg A's high-side command is on while the carrier is below T. T = m in the first half cycle and C-m in the second half cycle. Leg B's low side is on for the whole first half cycle and its high side for the whole second half cycle. Leg B changes only where m is 0.
- R7: Each gate registers its leg command with one clock of latency. After every command change, both gates of that leg stay off for dead_cnt clocks before the new side turns on. The high and low gates of a leg are never on together.
- R8: sync_o is high for exactly one clock per line cycle, in the first clock of carrier period 0.
- R9: While rst is high, both high-side gates are off, both low-side gates are on, and sync_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = two-level complementary, 1 = three-level |
| amp_scale | input | AMP_W | Amplitude gain, 2^AMP_FRAC is unity |
| dead_cnt | input | DT_W | Dead time in clocks per leg transition |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |
| sync_o | output | 1 | One-clock pulse at the start of each line cycle |

## Verification
The dead-time gap properties assume that dead_cnt holds steady across a leg transition, because they judge a rising gate by the count that was present when the leg command flipped. The bench changes dead_cnt, amp_scale and mode_sel only on a falling clock edge, right after a sync pulse, and then lets a full line cycle pass before it measures. The only exception is a deliberate mid-period change of amp_scale, which the bench uses to test when inputs are captured. The bench reads the gates per carrier period, aligned to sync_o, and compares the on-time counts with the thresholds it derives from the requirements.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic {
    MODE_TWO   = 1'b0,
    MODE_THREE = 1'b1
  } bridge_mode_e;

  // Parabolic half-wave shape: 4*h*(half-h)/half^2, scaled to full carrier count
  function automatic int shape_mag(int h, int half, int cmax);
    return (4 * h * (half - h) * cmax) / (half * half);
  endfunction

  // Amplitude gain with saturation at full duty
  function automatic int scale_sat(int mag, int amp, int frac, int cmax);
    int prod;
    prod = (mag * amp) >>> frac;
    return (prod > cmax) ? cmax : prod;
  endfunction

  // Compare threshold for leg A
  function automatic int leg_threshold(logic three, logic neg, int mag, int cmax);
    if (three) return neg ? (cmax - mag) : mag;
    return neg ? ((cmax - mag) / 2) : ((cmax + mag) / 2);
  endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CW = 6,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic [IW-1:0] idx_next,
  output logic          wrap,
  output logic          sync
);

  logic [IW-1:0] idx;

  always_comb begin
    wrap     = (cnt == {CW{1'b1}});
    idx_next = idx + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      idx  <= '0;
      sync <= 1'b0;
    end else begin
      cnt  <= cnt + CW'(1);
      if (wrap) idx <= idx_next;
      sync <= wrap && (idx_next == '0);
    end
  end

  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(idx));

  // R8
  sync_align_chk: assert property (@(posedge clk) disable iff (rst)
    sync |-> (cnt == '0 && idx == '0));

endmodule

// File: rtl/spwm_reference.sv
module spwm_reference import spwm_pkg::*; #(
  parameter int CW = 6,
  parameter int IW = 5,
  parameter int AW = 8,
  parameter int AF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] idx_next,
  input  logic [AW-1:0] amp,
  input  logic          mode_in,
  output logic [CW:0]   mag_q,
  output logic          neg_q,
  output bridge_mode_e  mode_q
);

  localparam int HALF = 1 << (IW - 1);
  localparam int CMAX = 1 << CW;

  logic [IW-2:0] half_pos;
  logic [CW:0]   mag_next;

  always_comb begin
    half_pos = idx_next[IW-2:0];
    mag_next = (CW+1)'(scale_sat(shape_mag(int'(half_pos), HALF, CMAX),
                                 int'(amp), AF, CMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      neg_q  <= 1'b0;
      mode_q <= MODE_TWO;
    end else if (load) begin
      mag_q  <= mag_next;
      neg_q  <= idx_next[IW-1];
      mode_q <= bridge_mode_e'(mode_in);
    end
  end

  // R4
  hold_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(mag_q) && $stable(neg_q) && $stable(mode_q)));

  // R6
  zero_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (neg_q != $past(neg_q)) |-> (mag_q == '0));

endmodule

// File: rtl/spwm_deadtime.sv
module spwm_deadtime #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd,
  input  logic [DW-1:0] dt,
  output logic          gate_hi,
  output logic          gate_lo
);

  logic          cmd_q;
  logic [DW-1:0] wait_q;
  logic          settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 1'b0;
      wait_q <= '0;
    end else if (cmd != cmd_q) begin
      cmd_q  <= cmd;
      wait_q <= dt;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - DW'(1);
    end
  end

  always_comb begin
    settled = (wait_q == '0);
    gate_hi = cmd_q & settled;
    gate_lo = ~cmd_q & settled;
  end

endmodule

// File: rtl/spwm_bridge_mod.sv
module spwm_bridge_mod import spwm_pkg::*; #(
  parameter int CARR_W   = 6,
  parameter int IDX_W    = 5,
  parameter int AMP_W    = 8,
  parameter int AMP_FRAC = 7,
  parameter int DT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic [AMP_W-1:0] amp_scale,
  input  logic [DT_W-1:0]  dead_cnt,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl,
  output logic             sync_o
);

  localparam int CMAX = 1 << CARR_W;
  localparam int NLEG = 2;

  logic [CARR_W-1:0] car_cnt;
  logic [IDX_W-1:0]  idx_next;
  logic              car_wrap;
  logic              line_sync;
  logic [CARR_W:0]   mag_q;
  logic              neg_q;
  bridge_mode_e      mode_q;
  logic [CARR_W:0]   thr_a;
  logic [NLEG-1:0]   leg_cmd;
  logic [NLEG-1:0]   gate_hi;
  logic [NLEG-1:0]   gate_lo;

  spwm_carrier #(.CW(CARR_W), .IW(IDX_W)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .cnt      (car_cnt),
    .idx_next (idx_next),
    .wrap     (car_wrap),
    .sync     (line_sync)
  );

  spwm_reference #(.CW(CARR_W), .IW(IDX_W), .AW(AMP_W), .AF(AMP_FRAC)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .load     (car_wrap),
    .idx_next (idx_next),
    .amp      (amp_scale),
    .mode_in  (mode_sel),
    .mag_q    (mag_q),
    .neg_q    (neg_q),
    .mode_q   (mode_q)
  );

  always_comb begin
    thr_a = (CARR_W+1)'(leg_threshold(mode_q == MODE_THREE, neg_q,
                                      int'(mag_q), CMAX));
    leg_cmd[0] = ({1'b0, car_cnt} < thr_a);
    leg_cmd[1] = (mode_q == MODE_THREE) ? neg_q : ~leg_cmd[0];
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    spwm_deadtime #(.DW(DT_W)) u_dt (
      .clk     (clk),
      .rst     (rst),
      .cmd     (leg_cmd[g]),
      .dt      (dead_cnt),
      .gate_hi (gate_hi[g]),
      .gate_lo (gate_lo[g])
    );
  end

  assign gate_ah = gate_hi[0];
  assign gate_al = gate_lo[0];
  assign gate_bh = gate_hi[1];
  assign gate_bl = gate_lo[1];
  assign sync_o  = line_sync;

  // R7
  gap_a_hi_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_ah) && $past(dead_cnt) != '0) |-> $past(!gate_al));

  // R7
  gap_a_lo_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_al) && $past(dead_cnt) != '0) |-> $past(!gate_ah));

  // R7
  gap_b_hi_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_bh) && $past(dead_cnt) != '0) |-> $past(!gate_bl));

  // R5
  two_level_comp_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_q) == MODE_TWO) && gate_ah) |-> !gate_bh);

endmodule

// File: tb/spwm_bridge_mod_test.sv
module spwm_bridge_mod_test;

  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 64;
  localparam int NPER = 32;
  localparam int HALF = 16;
  localparam int UNITY = 128;
  localparam int NVEC = 6;
  // {mode, amp}
  localparam int VEC [NVEC][2] = '{
    '{0, 128}, '{0, 64}, '{1, 128}, '{1, 200}, '{0, 255}, '{1, 0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic [7:0] amp_scale = 8'd0;
  logic [3:0] dead_cnt = 4'd0;
  logic       gate_ah, gate_al, gate_bh, gate_bl, sync_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spwm_bridge_mod uut (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .amp_scale (amp_scale),
    .dead_cnt  (dead_cnt),
    .gate_ah   (gate_ah),
    .gate_al   (gate_al),
    .gate_bh   (gate_bh),
    .gate_bl   (gate_bl),
    .sync_o    (sync_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected on-time of leg A per carrier period, from the requirements
  function automatic int exp_on(int mode, int amp, int k);
    int pos, sh, m;
    bit second;
    pos    = k % HALF;
    second = (k >= HALF);
    sh     = (CMAX * 4 * pos * (HALF - pos)) / (HALF * HALF);
    m      = (sh * amp) / UNITY;
    if (m > CMAX) m = CMAX;
    if (mode == 1) return second ? CMAX - m : m;
    return second ? (CMAX - m) / 2 : (CMAX + m) / 2;
  endfunction

  task automatic wait_sync();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sync_o && guard < 3 * NPER * CMAX);
    if (!sync_o) check("R8", "sync timeout", 0, 1);
  endtask

  task automatic count_period(output int ha, output int la, output int hb,
                              output int lb, output int sy, output int ov);
    ha = 0; la = 0; hb = 0; lb = 0; sy = 0; ov = 0;
    for (int i = 0; i < CMAX; i++) begin
      @(negedge clk);
      ha += int'(gate_ah); la += int'(gate_al);
      hb += int'(gate_bh); lb += int'(gate_bl);
      sy += int'(sync_o);
      if ((gate_ah && gate_al) || (gate_bh && gate_bl)) ov++;
    end
  endtask

  task automatic run_cycle(input int mode, input int amp, input string req);
    int ha, la, hb, lb, sy, ov, bad_sync, bad_ov, exp_b;
    bad_sync = 0; bad_ov = 0;
    for (int k = 0; k < NPER; k++) begin
      count_period(ha, la, hb, lb, sy, ov);
      check(req, $sformatf("leg A on k=%0d mode=%0d amp=%0d", k, mode, amp),
            ha, exp_on(mode, amp, k));
      if (mode == 1) exp_b = (k >= HALF) ? CMAX : 0;
      else exp_b = CMAX - exp_on(mode, amp, k);
      check(mode == 1 ? "R6" : "R5", $sformatf("leg B on k=%0d", k), hb, exp_b);
      if (sy != ((k == NPER - 1) ? 1 : 0)) bad_sync++;
      bad_ov += ov;
    end
    // R1 R8: one sync per 2048 clocks, at the first clock of period 0
    check("R8", "sync placement", bad_sync, 0);
    check("R7", "overlap", bad_ov, 0);
  endtask

  initial begin
    int ha, la, hb, lb, sy, ov;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9", "gate_ah in reset", int'(gate_ah), 0);
    check("R9", "gate_bh in reset", int'(gate_bh), 0);
    check("R9", "gate_al in reset", int'(gate_al), 1);
    check("R9", "gate_bl in reset", int'(gate_bl), 1);
    check("R9", "sync in reset", int'(sync_o), 0);
    rst = 1'b0;
    wait_sync();

    // Vector table: R2, R3, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      mode_sel  = VEC[v][0][0];
      amp_scale = 8'(VEC[v][1]);
      wait_sync();
      run_cycle(VEC[v][0], VEC[v][1], (VEC[v][1] > UNITY) ? "R3" : "R2");
    end

    // R4: amplitude change mid-period has no effect until the next wrap
    mode_sel = 1'b1; amp_scale = 8'd128; dead_cnt = 4'd0;
    wait_sync();
    for (int k = 0; k < 4; k++) count_period(ha, la, hb, lb, sy, ov);
    ha = 0;
    for (int i = 0; i < CMAX; i++) begin
      @(negedge clk);
      ha += int'(gate_ah);
      if (i == 10) amp_scale = 8'd64;
    end
    check("R4", "period with mid change", ha, 48);
    count_period(ha, la, hb, lb, sy, ov);
    check("R4", "period after change", ha, 27);
    wait_sync();

    // R7: dead time of 5 clocks, two-level
    mode_sel = 1'b0; amp_scale = 8'd128; dead_cnt = 4'd5;
    wait_sync();
    begin
      int tot_ov = 0;
      for (int k = 0; k < NPER; k++) begin
        count_period(ha, la, hb, lb, sy, ov);
        tot_ov += ov;
        if (k == 4) begin
          check("R7", "hi on k=4 dt=5", ha, 51);
          check("R7", "lo on k=4 dt=5", la, 3);
        end
        if (k == 20) begin
          check("R7", "hi on k=20 dt=5", ha, 3);
          check("R7", "lo on k=20 dt=5", la, 51);
        end
      end
      check("R7", "overlap dt=5", tot_ov, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule